// File: doc/BRIEF.md
# DRAM Read Command Spacing Tracker

This block watches the command stream of one memory channel and tracks how long ago each command that constrains a READ was issued. A scheduler asks it about one rank and bank. The block answers at once whether a READ to that target would honour every programmed minimum spacing. If a READ is issued before its spacings have elapsed, the block also raises a violation pulse on the next cycle.

Five spacings are enforced:

- activate to read, for the same rank and bank;
- write to read, with one value for the same rank and another for a different rank;
- read to read, with one value for the same rank and another for a different rank.

Each spacing is a 4- or 5-bit field of a 24-bit configuration word. The top three bits of that word are reserved. The channel has two ranks of eight banks by default.

Top module: `rd_spacing_tracker`

## Requirements
- R1: After reset the configuration reads as zero, `qry_rd_ok` is 1 for every target, and `rd_violation` is 0.
- R2: A write on `cfg_we` stores `cfg_wdata` in the configuration from the next cycle on. `cfg_rdata` returns that value, except that bits 23:21 always read 0 and writing ones to them has no effect.
- R3: Configuration bits 20:17 give the activate-to-read spacing. It blocks READs only to the rank and bank that was activated; other banks and other ranks are unaffected.
- R4: Bits 16:12 give the write-to-read spacing for a READ to the rank that was written.
- R5: Bits 11:8 give the write-to-read spacing for a READ to any rank other than the one written.
- R6: Bits 7:4 give the read-to-read spacing for two READs to the same rank.
- R7: Bits 3:0 give the read-to-read spacing for READs to different ranks.
- R8: A spacing of N issued at cycle c permits a READ at cycle c+N or later. N of 0 or 1 imposes no wait.
- R9: A new command of the same kind to the same target restarts its spacing from the value programmed at that moment, whether that gives a longer or a shorter wait.
- R10: `rd_violation` is 1 for exactly the one cycle after a READ issued while any applicable spacing had not elapsed; otherwise it is 0.
- R11: A command is counted only when `cmd_valid` is 1. `cmd_type` is encoded as 0 = NOP, 1 = ACT, 2 = READ, 3 = WRITE. NOPs and invalid cycles change no spacing and raise no violation.
- R12: `qry_rd_ok` is combinational in `qry_rank`/`qry_bank` and reflects the state of the current cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 24 | Configuration word to store |
| cfg_rdata | output | 24 | Stored configuration, reserved bits zero |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_type | input | 2 | 0 NOP, 1 ACT, 2 READ, 3 WRITE |
| cmd_rank | input | 1 | Rank addressed by the command |
| cmd_bank | input | 3 | Bank addressed by the command |
| qry_rank | input | 1 | Rank of the READ being asked about |
| qry_bank | input | 3 | Bank of the READ being asked about |
| qry_rd_ok | output | 1 | A READ to the queried target is allowed now |
| rd_violation | output | 1 | Previous cycle issued a READ too early |

## Verification
A counter that loads the wrong field, reloads at the wrong time, or is checked against the wrong rank changes `qry_rd_ok` within the spacing window that follows the offending command. The error appears as early as the first cycle after the command and no later than the last cycle of the programmed wait. The reference model predicts `qry_rd_ok` for every cycle of every window, so an error of one cycle at either edge of a window is visible. A READ issued into such a window also exposes the error one cycle later on `rd_violation`. The stimulus therefore mixes directed windows, with waits of 0, 1 and several cycles, with long random command streams under changing configurations.

// File: rtl/rd_spacing_tracker.sv
module rd_spacing_tracker #(
  parameter int RANKS = 2,
  parameter int BANKS = 8,
  parameter int RK_W  = $clog2(RANKS),
  parameter int BK_W  = $clog2(BANKS),
  parameter int CW    = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [23:0]     cfg_wdata,
  output logic [23:0]     cfg_rdata,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_type,
  input  logic [RK_W-1:0] cmd_rank,
  input  logic [BK_W-1:0] cmd_bank,
  input  logic [RK_W-1:0] qry_rank,
  input  logic [BK_W-1:0] qry_bank,
  output logic            qry_rd_ok,
  output logic            rd_violation
);
  localparam int NPAIR  = RANKS * BANKS;
  localparam int PAIR_W = RK_W + BK_W;
  localparam logic [1:0] OP_ACT = 2'd1;
  localparam logic [1:0] OP_RD  = 2'd2;
  localparam logic [1:0] OP_WR  = 2'd3;

  logic [20:0]   cfg_q;
  logic [CW-1:0] act_cnt [NPAIR];
  logic [CW-1:0] wrs_cnt [RANKS];
  logic [CW-1:0] wrd_cnt [RANKS];
  logic [CW-1:0] rds_cnt [RANKS];
  logic [CW-1:0] rdd_cnt [RANKS];
  logic [RANKS-1:0] other_busy;
  logic [RANKS-1:0] rank_clear;
  logic [CW-1:0] t_act, t_wrs, t_wrd, t_rrs, t_rrd;
  logic is_act, is_rd, is_wr, cmd_ok;

  function automatic logic [CW-1:0] minus1(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - CW'(1);
  endfunction

  assign t_act = CW'(cfg_q[20:17]);
  assign t_wrs = CW'(cfg_q[16:12]);
  assign t_wrd = CW'(cfg_q[11:8]);
  assign t_rrs = CW'(cfg_q[7:4]);
  assign t_rrd = CW'(cfg_q[3:0]);
  assign cfg_rdata = {3'b000, cfg_q};

  assign is_act = cmd_valid && cmd_type == OP_ACT;
  assign is_rd  = cmd_valid && cmd_type == OP_RD;
  assign is_wr  = cmd_valid && cmd_type == OP_WR;

  always_comb begin
    for (int r = 0; r < RANKS; r++) begin
      other_busy[r] = 1'b0;
      for (int o = 0; o < RANKS; o++)
        if (o != r && (wrd_cnt[o] != '0 || rdd_cnt[o] != '0))
          other_busy[r] = 1'b1;
      rank_clear[r] = wrs_cnt[r] == '0 && rds_cnt[r] == '0 && !other_busy[r];
    end
  end

  assign qry_rd_ok = rank_clear[qry_rank] && act_cnt[{qry_rank, qry_bank}] == '0;
  assign cmd_ok    = rank_clear[cmd_rank] && act_cnt[{cmd_rank, cmd_bank}] == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q        <= '0;
      rd_violation <= 1'b0;
      for (int i = 0; i < NPAIR; i++) act_cnt[i] <= '0;
      for (int r = 0; r < RANKS; r++) begin
        wrs_cnt[r] <= '0;
        wrd_cnt[r] <= '0;
        rds_cnt[r] <= '0;
        rdd_cnt[r] <= '0;
      end
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata[20:0];
      rd_violation <= is_rd && !cmd_ok;
      for (int i = 0; i < NPAIR; i++)
        act_cnt[i] <= (is_act && {cmd_rank, cmd_bank} == PAIR_W'(i))
                      ? minus1(t_act) : minus1(act_cnt[i]);
      for (int r = 0; r < RANKS; r++) begin
        if (is_wr && cmd_rank == RK_W'(r)) begin
          wrs_cnt[r] <= minus1(t_wrs);
          wrd_cnt[r] <= minus1(t_wrd);
        end else begin
          wrs_cnt[r] <= minus1(wrs_cnt[r]);
          wrd_cnt[r] <= minus1(wrd_cnt[r]);
        end
        if (is_rd && cmd_rank == RK_W'(r)) begin
          rds_cnt[r] <= minus1(t_rrs);
          rdd_cnt[r] <= minus1(t_rrd);
        end else begin
          rds_cnt[r] <= minus1(rds_cnt[r]);
          rdd_cnt[r] <= minus1(rdd_cnt[r]);
        end
      end
    end
  end

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[23:21] == 3'b000);

  p_viol_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_violation |-> $past(is_rd));

  p_viol_when_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && !cmd_ok) |=> rd_violation);

  p_viol_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && cmd_ok) |=> !rd_violation);

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair_chk
    p_act_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_act && {cmd_rank, cmd_bank} == PAIR_W'(p) && t_act >= CW'(2))
      |=> ({qry_rank, qry_bank} != PAIR_W'(p) || !qry_rd_ok));
  end

  for (genvar r = 0; r < RANKS; r++) begin : g_rank_chk
    p_wr_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && cmd_rank == RK_W'(r) && t_wrs >= CW'(2))
      |=> (qry_rank != RK_W'(r) || !qry_rd_ok));
    p_wr_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && cmd_rank == RK_W'(r) && t_wrd >= CW'(2))
      |=> (qry_rank == RK_W'(r) || !qry_rd_ok));
    p_rd_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && cmd_rank == RK_W'(r) && t_rrs >= CW'(2))
      |=> (qry_rank != RK_W'(r) || !qry_rd_ok));
    p_rd_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && cmd_rank == RK_W'(r) && t_rrd >= CW'(2))
      |=> (qry_rank == RK_W'(r) || !qry_rd_ok));
  end
endmodule

// File: tb/rd_spacing_tracker_bench.sv
`timescale 1ns/100ps
module rd_spacing_tracker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [23:0] cfg_wdata = '0;
  logic [23:0] cfg_rdata;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_type = '0;
  logic [0:0] cmd_rank = '0;
  logic [2:0] cmd_bank = '0;
  logic [0:0] qry_rank = '0;
  logic [2:0] qry_bank = '0;
  logic qry_rd_ok, rd_violation;

  always #2.5 clk = ~clk;

  rd_spacing_tracker u_rd_spacing_tracker (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .qry_rank(qry_rank),
    .qry_bank(qry_bank), .qry_rd_ok(qry_rd_ok), .rd_violation(rd_violation));

  int checks = 0, fails = 0, cyc = 0;
  int act_e [2][8];
  int wrs_e [2], wrd_e [2], rrs_e [2], rrd_e [2];
  logic [20:0] cfg_m = '0;
  bit viol_exp = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  function automatic bit m_ok(input int c, input int r, input int b, output string why);
    why = "R8";
    if (c < act_e[r][b]) begin why = "R3"; return 0; end
    if (c < wrs_e[r])    begin why = "R4"; return 0; end
    if (c < rrs_e[r])    begin why = "R6"; return 0; end
    for (int o = 0; o < 2; o++) begin
      if (o == r) continue;
      if (c < wrd_e[o]) begin why = "R5"; return 0; end
      if (c < rrd_e[o]) begin why = "R7"; return 0; end
    end
    return 1;
  endfunction

  task automatic step(input bit v, input int t, input int r, input int b,
                      input int qr, input int qb, input bit we, input logic [23:0] wd);
    string why, w2;
    bit e;
    cmd_valid = v; cmd_type = 2'(t); cmd_rank = 1'(r); cmd_bank = 3'(b);
    qry_rank = 1'(qr); qry_bank = 3'(qb); cfg_we = we; cfg_wdata = wd;
    #1;
    e = m_ok(cyc, qr, qb, why);
    check(qry_rd_ok == e, {why, " query (R12)"}, qry_rd_ok, e);
    check(rd_violation == viol_exp, "R10 violation", rd_violation, viol_exp);
    check(cfg_rdata == {3'b000, cfg_m}, "R2 readback", cfg_rdata, {3'b000, cfg_m});
    viol_exp = (v && t == 2) ? !m_ok(cyc, r, b, w2) : 1'b0;
    @(posedge clk);
    if (v) begin
      case (t)
        1: act_e[r][b] = cyc + int'(cfg_m[20:17]);
        2: begin rrs_e[r] = cyc + int'(cfg_m[7:4]);   rrd_e[r] = cyc + int'(cfg_m[3:0]); end
        3: begin wrs_e[r] = cyc + int'(cfg_m[16:12]); wrd_e[r] = cyc + int'(cfg_m[11:8]); end
        default: ;
      endcase
    end
    if (we) cfg_m = wd[20:0];
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input int qr, input int qb);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, qr, qb, 0, '0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  localparam logic [23:0] CFG_A = (24'd4 << 17) | (24'd6 << 12) | (24'd3 << 8) | (24'd5 << 4) | 24'd2;
  localparam logic [23:0] CFG_ONES = (24'd1 << 17) | (24'd1 << 12) | (24'd1 << 8) | (24'd1 << 4) | 24'd1;

  initial begin
    for (int r = 0; r < 2; r++) begin
      wrs_e[r] = 0; wrd_e[r] = 0; rrs_e[r] = 0; rrd_e[r] = 0;
      for (int b = 0; b < 8; b++) act_e[r][b] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(cfg_rdata == 24'h0, "R1 cfg after reset", cfg_rdata, 0);
    check(qry_rd_ok == 1'b1, "R1 read ok after reset", qry_rd_ok, 1);
    check(rd_violation == 1'b0, "R1 no violation after reset", rd_violation, 0);
    @(negedge clk);
    cyc = 1;
    // R1: zero config means no restriction, back-to-back traffic
    step(1, 3, 0, 0, 0, 0, 0, '0);
    step(1, 2, 0, 0, 0, 0, 0, '0);
    step(1, 1, 1, 2, 1, 2, 0, '0);
    step(1, 2, 1, 2, 1, 2, 0, '0);
    // R2 reserved bits written with ones are ignored
    step(0, 0, 0, 0, 0, 0, 1, 24'hFFFFFF);
    idle(1, 0, 0);
    check(cfg_rdata == 24'h1FFFFF, "R2 reserved bits", cfg_rdata, 24'h1FFFFF);
    step(0, 0, 0, 0, 0, 0, 1, CFG_A);
    // R3 activate window, same bank blocked, other bank and rank free
    step(1, 1, 0, 3, 0, 3, 0, '0);
    step(0, 0, 0, 0, 0, 4, 0, '0);
    step(1, 2, 0, 3, 1, 3, 0, '0);
    idle(6, 0, 3);
    // R4 and R5 write windows
    step(1, 3, 1, 0, 1, 5, 0, '0);
    idle(3, 0, 5);
    idle(4, 1, 5);
    step(1, 3, 1, 0, 0, 0, 0, '0);
    step(1, 2, 0, 1, 0, 1, 0, '0);
    idle(7, 1, 1);
    // R6 and R7 read windows
    step(1, 2, 0, 2, 0, 2, 0, '0);
    idle(2, 1, 2);
    idle(4, 0, 2);
    step(1, 2, 1, 6, 0, 6, 0, '0);
    step(1, 2, 1, 6, 1, 6, 0, '0);
    idle(6, 1, 6);
    // R9 reload lengthens and shortens the wait
    step(1, 3, 0, 1, 0, 1, 0, '0);
    idle(3, 0, 1);
    step(1, 3, 0, 1, 0, 1, 0, '0);
    idle(3, 0, 1);
    step(0, 0, 0, 0, 0, 1, 1, CFG_ONES);
    step(1, 3, 0, 1, 0, 1, 0, '0);
    idle(3, 0, 1);
    // R8 spacing of one: back-to-back reads after write, no violation
    step(1, 1, 1, 7, 1, 7, 0, '0);
    step(1, 2, 1, 7, 1, 7, 0, '0);
    step(1, 2, 0, 7, 0, 7, 0, '0);
    step(1, 3, 0, 7, 0, 7, 0, '0);
    step(1, 2, 0, 7, 1, 7, 0, '0);
    idle(2, 0, 0);
    // R11 invalid and NOP commands change nothing
    step(0, 0, 0, 0, 0, 0, 1, CFG_A);
    step(1, 3, 1, 4, 1, 4, 0, '0);
    step(0, 2, 1, 4, 1, 4, 0, '0);
    step(1, 0, 1, 4, 1, 4, 0, '0);
    step(0, 1, 0, 0, 0, 0, 0, '0);
    step(0, 3, 0, 0, 0, 0, 0, '0);
    idle(6, 0, 0);
    // random traffic under changing configurations
    for (int k = 0; k < 5000; k++) begin
      bit we = (k % 400) == 0;
      logic [23:0] wd = {$urandom} & 24'hFFFFFF;
      if (k % 800 == 400) wd = '0;
      step($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 1),
           $urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 7), we, wd);
    end
    idle(2, 0, 0);
    summary();
  end
endmodule